// File: doc/BRIEF.md
# String Move Engine with Repeat Prefix

This block carries out one element of a string move: it reads a byte or a word from the source segment and offset, and writes it to the destination segment and offset. It then steps both offsets by the element size, in the direction chosen by the direction flag. The surrounding sequencer pulses `start` with the prefix byte, the opcode byte, the direction flag and the current register values. It waits for `done`, then takes back the updated offsets and count.

When a repeat prefix comes with the opcode, the engine first checks that the opcode belongs to a string group. If it does not, the engine reports a bad prefix and leaves the opcode unconsumed. Otherwise it looks at the count. A zero count ends the instruction with no transfer. A non-zero count is decremented, one element is moved, and `repeat_again` tells the sequencer to step its instruction pointer back by two so that the prefixed instruction runs again. Memory is reached through a byte-wide port with combinational read data. Each byte costs one read cycle and then one write cycle.

Top module: `strmove_engine`

## Requirements
- R1: Opcode 0xA4 copies one byte from address ds*16 + si to address es*16 + di. Each 16-bit offset wraps modulo 65536 before the segment base is added.
- R2: Opcode 0xA5 copies two bytes, the low byte first. The second byte is at offset+1 on each side, wrapped modulo 65536.
- R3: After a transfer, `si_out` and `di_out` both change by the element size (1 for 0xA4, 2 for 0xA5). They decrease when `dir_flag` is 1 and increase when it is 0.
- R4: A `prefix` of 0xF2 or 0xF3 marks a repeat. Under repeat, only the opcodes 0x6C–0x6F, 0xA4–0xA7, 0xAA–0xAB and 0xAC–0xAF are accepted. Any other opcode ends with `bad_prefix`=1 and `repeat_again`=0, with all registers unchanged and no memory write.
- R5: Under repeat with `cx_in`=0, the instruction ends with no transfer, the registers unchanged and `repeat_again`=0.
- R6: Under repeat with `cx_in`≠0, the count is decremented by one. For 0xA4/0xA5, one element is moved and `repeat_again`=1. For other accepted opcodes, nothing is moved and `repeat_again`=0.
- R7: The repeat prefix costs 4 wait cycles, and each moved element costs 4 wait cycles followed by one read cycle and one write cycle per byte. Counted in clock edges from the edge that samples `start`, `done` appears after 1 + (repeat ? 4 : 0) + (transfer ? 4 + 2*size : 0) edges.
- R8: `done` is high for exactly one cycle per accepted `start`, and the outputs hold their values afterwards. A `start` that arrives while the engine is busy is ignored.
- R9: Without a repeat prefix, `cx_out` equals `cx_in`. An opcode other than 0xA4/0xA5 completes after one edge and does nothing.
- R10: After reset, `done`, `mem_rd`, `mem_wr` and all register outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one element; sampled only when idle |
| prefix | input | 8 | Prefix byte (0xF2/0xF3 = repeat, anything else = none) |
| opcode | input | 8 | String opcode byte |
| dir_flag | input | 1 | 1 = offsets decrement |
| si_in | input | 16 | Source offset |
| di_in | input | 16 | Destination offset |
| cx_in | input | 16 | Repeat count |
| ds_in | input | 16 | Source segment |
| es_in | input | 16 | Destination segment |
| mem_addr | output | 20 | Byte address |
| mem_rd | output | 1 | Read strobe; data taken the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| si_out | output | 16 | Updated source offset |
| di_out | output | 16 | Updated destination offset |
| cx_out | output | 16 | Updated count |
| done | output | 1 | One-cycle completion pulse |
| repeat_again | output | 1 | Re-execute the prefixed instruction |
| bad_prefix | output | 1 | Opcode not valid after a repeat prefix |

## Verification
The assertions assume that the memory returns read data combinationally in the cycle where `mem_rd` is high. They also assume that both wait parameters are at least one, and they relate the read and write strobes and the zero-count and bad-prefix exits to that timing. The bench models the memory as a combinational array and keeps every source offset in one 256-byte window and every destination offset in another. It raises `start` only while the engine is idle, except in one directed test that deliberately pulses `start` mid-operation to show it is ignored.

// File: rtl/strmove_engine.sv
module strmove_engine #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PFX_WAIT  = 4,
  parameter int ELEM_WAIT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [7:0]                 prefix,
  input  logic [7:0]                 opcode,
  input  logic                       dir_flag,
  input  logic [OFF_W-1:0]           si_in,
  input  logic [OFF_W-1:0]           di_in,
  input  logic [OFF_W-1:0]           cx_in,
  input  logic [OFF_W-1:0]           ds_in,
  input  logic [OFF_W-1:0]           es_in,
  output logic [OFF_W+SEG_SHIFT-1:0] mem_addr,
  output logic                       mem_rd,
  output logic                       mem_wr,
  output logic [7:0]                 mem_wdata,
  input  logic [7:0]                 mem_rdata,
  output logic [OFF_W-1:0]           si_out,
  output logic [OFF_W-1:0]           di_out,
  output logic [OFF_W-1:0]           cx_out,
  output logic                       done,
  output logic                       repeat_again,
  output logic                       bad_prefix
);
  localparam int AW   = OFF_W + SEG_SHIFT;
  localparam int MAXW = (PFX_WAIT > ELEM_WAIT) ? PFX_WAIT : ELEM_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {S_IDLE, S_PFX, S_WAIT, S_RD, S_WR, S_FIN} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [OFF_W-1:0] si_q, di_q, cx_q, ds_q, es_q;
  logic [7:0]       op_q, buf_q;
  logic             dir_q, rep_q, hi_q, again_q, inv_q;

  wire in_rep   = (prefix == 8'hF2) || (prefix == 8'hF3);
  wire in_move  = (opcode[7:1] == 7'h52);
  wire is_move  = (op_q[7:1] == 7'h52);
  wire is_word  = op_q[0];
  wire op_valid = (op_q[7:2] == 6'h1B) || (op_q[7:2] == 6'h29) ||
                  (op_q[7:1] == 7'h55) || (op_q[7:2] == 6'h2B);

  wire [OFF_W-1:0] step    = is_word ? OFF_W'(2) : OFF_W'(1);
  wire [OFF_W-1:0] si_next = dir_q ? si_q - step : si_q + step;
  wire [OFF_W-1:0] di_next = dir_q ? di_q - step : di_q + step;
  wire [OFF_W-1:0] src_off = si_q + OFF_W'(hi_q);
  wire [OFF_W-1:0] dst_off = di_q + OFF_W'(hi_q);
  wire [AW-1:0]    src_adr = {ds_q, {SEG_SHIFT{1'b0}}} + AW'(src_off);
  wire [AW-1:0]    dst_adr = {es_q, {SEG_SHIFT{1'b0}}} + AW'(dst_off);

  assign mem_rd       = (st == S_RD);
  assign mem_wr       = (st == S_WR);
  assign mem_addr     = mem_rd ? src_adr : dst_adr;
  assign mem_wdata    = buf_q;
  assign done         = (st == S_FIN);
  assign si_out       = si_q;
  assign di_out       = di_q;
  assign cx_out       = cx_q;
  assign repeat_again = again_q;
  assign bad_prefix   = inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0;
      si_q <= '0; di_q <= '0; cx_q <= '0; ds_q <= '0; es_q <= '0;
      op_q <= '0; buf_q <= '0;
      dir_q <= 1'b0; rep_q <= 1'b0; hi_q <= 1'b0; again_q <= 1'b0; inv_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          si_q <= si_in; di_q <= di_in; cx_q <= cx_in; ds_q <= ds_in; es_q <= es_in;
          op_q <= opcode; dir_q <= dir_flag; rep_q <= in_rep;
          hi_q <= 1'b0; again_q <= 1'b0; inv_q <= 1'b0;
          if (in_rep) begin
            st <= S_PFX; cnt <= CW'(PFX_WAIT - 1);
          end else if (in_move) begin
            st <= S_WAIT; cnt <= CW'(ELEM_WAIT - 1);
          end else begin
            st <= S_FIN;
          end
        end
        S_PFX: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!op_valid) begin
            inv_q <= 1'b1; st <= S_FIN;
          end else if (cx_q == '0) st <= S_FIN;
          else begin
            cx_q <= cx_q - 1'b1;
            if (is_move) begin
              st <= S_WAIT; cnt <= CW'(ELEM_WAIT - 1);
            end else st <= S_FIN;
          end
        end
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= S_RD;
        end
        S_RD: begin
          buf_q <= mem_rdata; st <= S_WR;
        end
        S_WR: begin
          if (is_word && !hi_q) begin
            hi_q <= 1'b1; st <= S_RD;
          end else begin
            si_q <= si_next; di_q <= di_next; again_q <= rep_q; st <= S_FIN;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R7
  AST_CX_ZERO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PFX && cnt == '0 && op_valid && cx_q == '0) |=> (done && cx_out == '0 && !repeat_again)); // R5
  AST_BAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PFX && cnt == '0 && !op_valid) |=> (done && bad_prefix && !repeat_again && $stable(cx_out))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(si_out) && $stable(di_out) && $stable(cx_out))); // R8
endmodule

// File: tb/tb_strmove_engine.sv
module tb_strmove_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  prefix = '0, opcode = '0;
  logic        dir_flag = 1'b0;
  logic [15:0] si_in = '0, di_in = '0, cx_in = '0;
  logic [15:0] ds_in = 16'h0010, es_in = 16'h0020;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] si_out, di_out, cx_out;
  logic        done, repeat_again, bad_prefix;

  always #4 clk = ~clk;

  strmove_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prefix(prefix), .opcode(opcode),
    .dir_flag(dir_flag), .si_in(si_in), .di_in(di_in), .cx_in(cx_in),
    .ds_in(ds_in), .es_in(es_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .done(done),
    .repeat_again(repeat_again), .bad_prefix(bad_prefix));

  logic [7:0] mem [0:1023];
  int         wr_seen;
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_wr) begin
    mem[mem_addr[9:0]] <= mem_wdata;
    wr_seen = wr_seen + 1;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idx(input logic [15:0] seg, input logic [15:0] off, input int k);
    logic [15:0] o;
    logic [19:0] a;
    o = off + 16'(k);
    a = {seg, 4'b0} + {4'b0, o};
    return int'(a[9:0]);
  endfunction

  task automatic run(input logic [7:0] p, input logic [7:0] o, input logic d,
                     input logic [15:0] s, input logic [15:0] dd, input logic [15:0] c,
                     input bit poke, output int lat);
    @(negedge clk);
    prefix = p; opcode = o; dir_flag = d; si_in = s; di_in = dd; cx_in = c;
    start = 1'b1; wr_seen = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      if (poke && lat == 2) begin start = 1'b1; prefix = 8'h00; opcode = 8'h90; end
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end
    if (lat >= 200) chk(1'b0, "watchdog R8", lat, 0);
  endtask

  // {prefix, opcode, 3'b0, dir, si, di, cx, exp_si, exp_di, exp_cx, inv, again, nwr[1:0], lat[7:0]}
  localparam logic [127:0] VEC [15] = '{
    {8'h00, 8'hA4, 4'h0, 16'h0010, 16'h0040, 16'h0005, 16'h0011, 16'h0041, 16'h0005, 1'b0, 1'b0, 2'd1, 8'd7},
    {8'h00, 8'hA5, 4'h0, 16'h0020, 16'h0050, 16'h0000, 16'h0022, 16'h0052, 16'h0000, 1'b0, 1'b0, 2'd2, 8'd9},
    {8'h00, 8'hA5, 4'h1, 16'h0030, 16'h0060, 16'h0003, 16'h002E, 16'h005E, 16'h0003, 1'b0, 1'b0, 2'd2, 8'd9},
    {8'hF3, 8'hA4, 4'h0, 16'h0012, 16'h0044, 16'h0003, 16'h0013, 16'h0045, 16'h0002, 1'b0, 1'b1, 2'd1, 8'd11},
    {8'hF2, 8'hA5, 4'h1, 16'h0034, 16'h0064, 16'h0002, 16'h0032, 16'h0062, 16'h0001, 1'b0, 1'b1, 2'd2, 8'd13},
    {8'hF3, 8'hA4, 4'h0, 16'h0010, 16'h0040, 16'h0000, 16'h0010, 16'h0040, 16'h0000, 1'b0, 1'b0, 2'd0, 8'd5},
    {8'hF3, 8'h90, 4'h0, 16'h0010, 16'h0040, 16'h0004, 16'h0010, 16'h0040, 16'h0004, 1'b1, 1'b0, 2'd0, 8'd5},
    {8'hF3, 8'hAA, 4'h0, 16'h0010, 16'h0040, 16'h0004, 16'h0010, 16'h0040, 16'h0003, 1'b0, 1'b0, 2'd0, 8'd5},
    {8'hF2, 8'h6C, 4'h1, 16'h0010, 16'h0040, 16'h0001, 16'h0010, 16'h0040, 16'h0000, 1'b0, 1'b0, 2'd0, 8'd5},
    {8'hF3, 8'hA8, 4'h0, 16'h0010, 16'h0040, 16'h0004, 16'h0010, 16'h0040, 16'h0004, 1'b1, 1'b0, 2'd0, 8'd5},
    {8'h00, 8'h90, 4'h0, 16'h0010, 16'h0040, 16'h0007, 16'h0010, 16'h0040, 16'h0007, 1'b0, 1'b0, 2'd0, 8'd1},
    {8'h00, 8'hA5, 4'h0, 16'hFFFF, 16'h0070, 16'h0009, 16'h0001, 16'h0072, 16'h0009, 1'b0, 1'b0, 2'd2, 8'd9},
    {8'hF3, 8'hA4, 4'h1, 16'h0000, 16'h0080, 16'h0001, 16'hFFFF, 16'h007F, 16'h0000, 1'b0, 1'b1, 2'd1, 8'd11},
    {8'hF2, 8'hAF, 4'h0, 16'h0010, 16'h0040, 16'h0002, 16'h0010, 16'h0040, 16'h0001, 1'b0, 1'b0, 2'd0, 8'd5},
    {8'hF3, 8'hA3, 4'h0, 16'h0010, 16'h0040, 16'h0002, 16'h0010, 16'h0040, 16'h0002, 1'b1, 1'b0, 2'd0, 8'd5}
  };

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    wr_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(!done && !mem_rd && !mem_wr, "R10 strobes", {done, mem_rd, mem_wr}, 0);
    chk(si_out == 0 && di_out == 0 && cx_out == 0 && !repeat_again && !bad_prefix,
        "R10 regs", {si_out, di_out}, 0);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      logic [127:0] e;
      logic [7:0]   sb [2];
      int           lat, nw;
      e  = VEC[v];
      nw = int'(e[9:8]);
      for (int k = 0; k < 2; k++) sb[k] = mem[idx(16'h0010, e[107:92], k)];
      run(e[127:120], e[119:112], e[108], e[107:92], e[91:76], e[75:60], 1'b0, lat);
      // R3 R9 R6 R5 R4: register results
      chk(si_out == e[59:44] && di_out == e[43:28], "R3 offsets", {si_out, di_out}, {e[59:44], e[43:28]});
      chk(cx_out == e[27:12], "R6 R9 R5 count", cx_out, e[27:12]);
      chk(bad_prefix == e[11] && repeat_again == e[10], "R4 R6 flags",
          {bad_prefix, repeat_again}, {e[11], e[10]});
      chk(lat == int'(e[7:0]), "R7 latency", lat, e[7:0]);
      chk(wr_seen == nw, "R5 R4 write count", wr_seen, nw);
      for (int k = 0; k < nw; k++)
        chk(mem[idx(16'h0020, e[91:76], k)] == sb[k], "R1 R2 data",
            mem[idx(16'h0020, e[91:76], k)], sb[k]);
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
    end

    // R8: start while busy is ignored
    begin
      int lat;
      logic [7:0] b0;
      b0 = mem[idx(16'h0010, 16'h0015, 0)];
      run(8'h00, 8'hA4, 1'b0, 16'h0015, 16'h00A0, 16'h0003, 1'b1, lat);
      chk(lat == 7 && si_out == 16'h0016 && di_out == 16'h00A1, "R8 busy start ignored", lat, 7);
      chk(mem[idx(16'h0020, 16'h00A0, 0)] == b0, "R1 data under poke", mem[idx(16'h0020, 16'h00A0, 0)], b0);
      repeat (3) @(negedge clk);
      chk(!done && !mem_rd, "R8 no second run", {done, mem_rd}, 0);
    end

    // R6 R5: full repeat loop driven by feeding outputs back
    begin
      logic [15:0] s, dd, c;
      int lat, iters;
      logic [7:0] sb [6];
      for (int k = 0; k < 6; k++) sb[k] = mem[idx(16'h0010, 16'h00C0, k)];
      s = 16'h00C0; dd = 16'h00D0; c = 16'h0003; iters = 0;
      do begin
        run(8'hF3, 8'hA5, 1'b0, s, dd, c, 1'b0, lat);
        s = si_out; dd = di_out; c = cx_out; iters++;
      end while (repeat_again && iters < 10);
      chk(iters == 4 && c == 0, "R6 loop iterations", iters, 4);
      chk(s == 16'h00C6 && dd == 16'h00D6, "R3 loop offsets", {s, dd}, {16'h00C6, 16'h00D6});
      for (int k = 0; k < 6; k++)
        chk(mem[idx(16'h0020, 16'h00D0, k)] == sb[k], "R2 loop data", mem[idx(16'h0020, 16'h00D0, k)], sb[k]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule